// File: doc/BRIEF.md
# Five-Port Micro-Op Dispatch Arbiter

This block holds a small pool of pending micro-ops and, in every cycle, picks the ones that go to five execution ports. Each pool entry carries a class code that says which ports may take it, a ready bit, and a tag that the block passes out with the grant. The classes are: a single ALU port only (port 0), the other ALU port only (port 1), either ALU port, the load port (port 2), and a store. A store needs the address port (3) and the data port (4) together in the same cycle. The grants are combinational on the current pool contents and the per-port busy mask. Every granted entry leaves the pool at the next rising clock edge.

The pool collapses toward slot 0, so the slot index is the age: slot 0 holds the oldest entry. Each cycle at most one new micro-op can be written, and it goes in behind the surviving entries. A wake-up strobe with a tag sets the ready bit of every entry whose tag matches. Port-0-only and port-1-only micro-ops take their ports before the flexible ones. The oldest flexible micro-op takes port 0 if that port is still free, otherwise port 1. A second flexible micro-op fills port 1 when both ALU ports were left free.

A three-state occupancy FSM (EMPTY, PARTIAL, FULL) controls admission. Its transitions are: *fill* (EMPTY to PARTIAL, or straight to FULL when one write completes the pool), *drain* (PARTIAL to EMPTY), *top-off* (PARTIAL to FULL) and *release* (FULL to PARTIAL, or to EMPTY when every entry leaves at once). In FULL the block refuses new writes.

Top module: `uop_port_arbiter`

## Requirements
- R1: Class codes are 0 = port 0 only, 1 = port 1 only, 2 = port 0 or 1, 3 = load, 4 = store. Class 0 is granted only on port 0, class 1 only on port 1, and class 3 only on port 2. Bit k of `grant_valid` and field k of `grant_tag` (bits k*TAG_W upward) belong to port k.
- R2: A store is granted only when ports 3 and 4 are both not busy. Both ports then carry the same tag in that cycle.
- R3: A ready class-0 or class-1 entry takes its port before any class-2 entry, even an older one.
- R4: The oldest ready class-2 entry takes port 0 if that port is left free, otherwise port 1. When both ALU ports are left free, the second-oldest class-2 entry takes port 1.
- R5: Among ready entries that compete for the same port, the oldest one (lowest pool slot) wins.
- R6: No grant is given on a port whose `port_busy` bit is 1.
- R7: Only entries with their ready bit set are granted. A `wake_valid` pulse sets the ready bit of every entry whose tag equals `wake_tag`, and the entry can be granted from the next cycle. A wake-up with a tag that matches nothing has no effect.
- R8: Granted entries leave the pool at the next rising edge. The survivors keep their relative order, and `pool_count` drops by the number of entries granted.
- R9: A write is accepted only when `alloc_valid` is 1, the class code is 0 to 4, and the pool is not FULL. A write with class 5 to 7, or a write while FULL, leaves the pool unchanged.
- R10: After reset the pool is empty, no grant is given, and `pool_full` is 0. `pool_full` is 1 exactly when `pool_count` equals DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Write a new micro-op this cycle |
| alloc_class | input | 3 | Class code of the new micro-op |
| alloc_ready | input | 1 | Initial ready bit of the new micro-op |
| alloc_tag | input | TAG_W | Tag of the new micro-op |
| wake_valid | input | 1 | Wake-up strobe |
| wake_tag | input | TAG_W | Tag to mark ready |
| port_busy | input | 5 | Per-port busy mask, bit k for port k |
| grant_valid | output | 5 | Per-port grant, bit k for port k |
| grant_tag | output | 5*TAG_W | Granted tag per port, field k for port k |
| pool_count | output | $clog2(DEPTH+1) | Number of pool entries |
| pool_full | output | 1 | Pool is in the FULL state |

## Verification
The embedded assertions check, on every cycle, the rules that hold under any input:
- no grant on a busy port;
- the store pair and its shared tag;
- only ready, present entries are removed;
- each port picks at most one entry;
- port 0 never goes to a flexible entry while a fixed one is waiting;
- the count update rule;
- agreement between the FSM's full flag and the counter.

Which entry wins is a different matter, so the bench scenarios have to show it. That covers age order within a class, how flexible entries split across the two ALU ports, collapse order during a drain, and the one-cycle delay after a wake-up.

// File: rtl/uop_arb_pkg.sv
package uop_arb_pkg;

    localparam int NPORT = 5;

    localparam logic [2:0] CLS_P0    = 3'd0;
    localparam logic [2:0] CLS_P1    = 3'd1;
    localparam logic [2:0] CLS_FLEX  = 3'd2;
    localparam logic [2:0] CLS_LOAD  = 3'd3;
    localparam logic [2:0] CLS_STORE = 3'd4;

    typedef enum logic [1:0] {
        ST_EMPTY   = 2'd0,
        ST_PARTIAL = 2'd1,
        ST_FULL    = 2'd2
    } pool_state_e;

    function automatic logic class_legal(input logic [2:0] c);
        return c <= CLS_STORE;
    endfunction

endpackage

// File: rtl/uop_oldest_pick.sv
module uop_oldest_pick #(
    parameter int N = 8
) (
    input  logic [N-1:0] req,
    output logic         hit,
    output logic [N-1:0] sel
);
    // lowest set bit = oldest requester
    assign sel = req & (~req + N'(1));
    assign hit = |req;
endmodule

// File: rtl/uop_pool.sv
module uop_pool #(
    parameter int N     = 8,
    parameter int TAG_W = 4,
    localparam int CNT_W = $clog2(N + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     remove,
    input  logic             alloc_en,
    input  logic [2:0]       alloc_cls,
    input  logic             alloc_rdy,
    input  logic [TAG_W-1:0] alloc_tag,
    input  logic             wake_valid,
    input  logic [TAG_W-1:0] wake_tag,
    output logic [N-1:0]     ent_valid,
    output logic [N-1:0]     ent_rdy,
    output logic [2:0]       ent_cls [N],
    output logic [TAG_W-1:0] ent_tag [N],
    output logic [CNT_W-1:0] count
);
    logic [2:0]       cls_q [N];
    logic [TAG_W-1:0] tag_q [N];
    logic [N-1:0]     rdy_q;
    logic [CNT_W-1:0] count_q;

    logic [2:0]       cls_d [N];
    logic [TAG_W-1:0] tag_d [N];
    logic [N-1:0]     rdy_d;
    logic [CNT_W-1:0] count_d;

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_valid
            assign ent_valid[g] = CNT_W'(g) < count_q;
        end
    endgenerate

    // collapse survivors toward slot 0, then append the new entry
    always_comb begin
        logic [CNT_W-1:0] wp;
        wp = '0;
        for (int i = 0; i < N; i++) begin
            cls_d[i] = '0;
            tag_d[i] = '0;
            rdy_d[i] = 1'b0;
        end
        for (int i = 0; i < N; i++) begin
            if (ent_valid[i] && !remove[i]) begin
                cls_d[wp[$clog2(N)-1:0]] = cls_q[i];
                tag_d[wp[$clog2(N)-1:0]] = tag_q[i];
                rdy_d[wp[$clog2(N)-1:0]] = rdy_q[i] | (wake_valid && (wake_tag == tag_q[i]));
                wp = wp + CNT_W'(1);
            end
        end
        if (alloc_en && (wp < CNT_W'(N))) begin
            cls_d[wp[$clog2(N)-1:0]] = alloc_cls;
            tag_d[wp[$clog2(N)-1:0]] = alloc_tag;
            rdy_d[wp[$clog2(N)-1:0]] = alloc_rdy | (wake_valid && (wake_tag == alloc_tag));
            wp = wp + CNT_W'(1);
        end
        count_d = wp;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
            rdy_q   <= '0;
            for (int i = 0; i < N; i++) begin
                cls_q[i] <= '0;
                tag_q[i] <= '0;
            end
        end else begin
            count_q <= count_d;
            rdy_q   <= rdy_d;
            for (int i = 0; i < N; i++) begin
                cls_q[i] <= cls_d[i];
                tag_q[i] <= tag_d[i];
            end
        end
    end

    assign ent_rdy = rdy_q;
    assign ent_cls = cls_q;
    assign ent_tag = tag_q;
    assign count   = count_q;

    // R7: only present, ready entries may be removed
    a_r7_ready_only: assert property (@(posedge clk) disable iff (!rst_n)
        (remove & ~(ent_valid & rdy_q)) == '0);

    // R8: count moves by writes minus removals
    a_r8_count_track: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> int'(count_q) == int'($past(count_q)) + int'($past(alloc_en))
                                  - $past($countones(remove)));

    // R9: never more entries than slots
    a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CNT_W'(N));
endmodule

// File: rtl/uop_port_alloc.sv
module uop_port_alloc
    import uop_arb_pkg::*;
#(
    parameter int N = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     ent_valid,
    input  logic [N-1:0]     ent_rdy,
    input  logic [2:0]       ent_cls [N],
    input  logic [NPORT-1:0] port_busy,
    output logic [N-1:0]     port_sel [NPORT],
    output logic [N-1:0]     remove
);
    localparam int NCLS = 5;

    logic [N-1:0] req_c [NCLS];
    logic [N-1:0] sel_c [NCLS];
    logic [NCLS-1:0] hit_c;
    logic [N-1:0] flex2_req, flex2_sel;
    logic         flex2_hit;

    genvar c, i;
    generate
        for (c = 0; c < NCLS; c++) begin : g_cls
            for (i = 0; i < N; i++) begin : g_ent
                assign req_c[c][i] = ent_valid[i] && ent_rdy[i] && (ent_cls[i] == 3'(c));
            end
            uop_oldest_pick #(.N(N)) u_pick (
                .req (req_c[c]),
                .hit (hit_c[c]),
                .sel (sel_c[c])
            );
        end
    endgenerate

    assign flex2_req = req_c[CLS_FLEX] & ~sel_c[CLS_FLEX];

    uop_oldest_pick #(.N(N)) u_pick_flex2 (
        .req (flex2_req),
        .hit (flex2_hit),
        .sel (flex2_sel)
    );

    logic fix0, fix1, free0, free1, st_ok;

    always_comb begin
        fix0  = hit_c[CLS_P0] && !port_busy[0];
        fix1  = hit_c[CLS_P1] && !port_busy[1];
        free0 = !port_busy[0] && !hit_c[CLS_P0];
        free1 = !port_busy[1] && !hit_c[CLS_P1];
        st_ok = hit_c[CLS_STORE] && !port_busy[3] && !port_busy[4];

        port_sel[0] = '0;
        if (fix0)
            port_sel[0] = sel_c[CLS_P0];
        else if (free0 && hit_c[CLS_FLEX])
            port_sel[0] = sel_c[CLS_FLEX];

        port_sel[1] = '0;
        if (fix1)
            port_sel[1] = sel_c[CLS_P1];
        else if (free1 && !free0 && hit_c[CLS_FLEX])
            port_sel[1] = sel_c[CLS_FLEX];
        else if (free1 && free0 && flex2_hit)
            port_sel[1] = flex2_sel;

        port_sel[2] = (!port_busy[2] && hit_c[CLS_LOAD]) ? sel_c[CLS_LOAD] : '0;
        port_sel[3] = st_ok ? sel_c[CLS_STORE] : '0;
        port_sel[4] = st_ok ? sel_c[CLS_STORE] : '0;

        remove = port_sel[0] | port_sel[1] | port_sel[2] | port_sel[3];
    end

    // R5: each port selects at most one entry
    a_r5_single_pick: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(port_sel[0]) && $onehot0(port_sel[1]) && $onehot0(port_sel[2])
        && $onehot0(port_sel[3]));

    // R3: port 0 never goes to a flexible entry while a ready port-0 entry waits
    a_r3_fixed_first: assert property (@(posedge clk) disable iff (!rst_n)
        (|(port_sel[0] & req_c[CLS_FLEX])) |-> !(|req_c[CLS_P0]));

    // R4: the two ALU ports never take the same entry
    a_r4_distinct_alu: assert property (@(posedge clk) disable iff (!rst_n)
        (port_sel[0] & port_sel[1]) == '0);
endmodule

// File: rtl/uop_port_arbiter.sv
module uop_port_arbiter
    import uop_arb_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int TAG_W = 4,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   alloc_valid,
    input  logic [2:0]             alloc_class,
    input  logic                   alloc_ready,
    input  logic [TAG_W-1:0]       alloc_tag,
    input  logic                   wake_valid,
    input  logic [TAG_W-1:0]       wake_tag,
    input  logic [4:0]             port_busy,
    output logic [4:0]             grant_valid,
    output logic [5*TAG_W-1:0]     grant_tag,
    output logic [CNT_W-1:0]       pool_count,
    output logic                   pool_full
);
    logic [DEPTH-1:0] ent_valid, ent_rdy, remove;
    logic [2:0]       ent_cls [DEPTH];
    logic [TAG_W-1:0] ent_tag [DEPTH];
    logic [DEPTH-1:0] port_sel [NPORT];
    logic             accept;

    pool_state_e state_q, state_d;

    uop_pool #(.N(DEPTH), .TAG_W(TAG_W)) u_pool (
        .clk        (clk),
        .rst_n      (rst_n),
        .remove     (remove),
        .alloc_en   (accept),
        .alloc_cls  (alloc_class),
        .alloc_rdy  (alloc_ready),
        .alloc_tag  (alloc_tag),
        .wake_valid (wake_valid),
        .wake_tag   (wake_tag),
        .ent_valid  (ent_valid),
        .ent_rdy    (ent_rdy),
        .ent_cls    (ent_cls),
        .ent_tag    (ent_tag),
        .count      (pool_count)
    );

    uop_port_alloc #(.N(DEPTH)) u_alloc (
        .clk       (clk),
        .rst_n     (rst_n),
        .ent_valid (ent_valid),
        .ent_rdy   (ent_rdy),
        .ent_cls   (ent_cls),
        .port_busy (port_busy),
        .port_sel  (port_sel),
        .remove    (remove)
    );

    // per-port tag mux from one-hot selections
    genvar p;
    generate
        for (p = 0; p < NPORT; p++) begin : g_port
            always_comb begin
                grant_tag[p*TAG_W +: TAG_W] = '0;
                for (int i = 0; i < DEPTH; i++) begin
                    if (port_sel[p][i])
                        grant_tag[p*TAG_W +: TAG_W] = grant_tag[p*TAG_W +: TAG_W] | ent_tag[i];
                end
            end
            assign grant_valid[p] = |port_sel[p];
        end
    endgenerate

    // occupancy FSM: next-state process
    always_comb begin
        int net;
        net     = int'(pool_count) + int'(accept) - $countones(remove);
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: begin
                if (accept)                               // fill
                    state_d = (net == DEPTH) ? ST_FULL : ST_PARTIAL;
            end
            ST_PARTIAL: begin
                if (net == 0)          state_d = ST_EMPTY;   // drain
                else if (net == DEPTH) state_d = ST_FULL;    // top-off
            end
            ST_FULL: begin
                if (remove != '0)                         // release
                    state_d = (net == 0) ? ST_EMPTY : ST_PARTIAL;
            end
            default: state_d = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    // occupancy FSM: output process
    always_comb begin
        pool_full = (state_q == ST_FULL);
        accept    = alloc_valid && class_legal(alloc_class) && (state_q != ST_FULL);
    end

    // R6: busy ports stay idle
    a_r6_busy_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid & port_busy) == 5'b0);

    // R2: store address and data ports are granted as a pair with one tag
    a_r2_store_pair: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid[3] == grant_valid[4]) &&
        (!grant_valid[3] || grant_tag[3*TAG_W +: TAG_W] == grant_tag[4*TAG_W +: TAG_W]));

    // R10: FSM full flag agrees with the occupancy counter
    a_r10_full_flag: assert property (@(posedge clk) disable iff (!rst_n)
        pool_full == (pool_count == CNT_W'(DEPTH)));
endmodule

// File: tb/sim_uop_port_arbiter.sv
module sim_uop_port_arbiter;
    localparam int PERIOD = 10;
    localparam int DEPTH  = 8;
    localparam int TAG_W  = 4;

    localparam logic [2:0] P0 = 3'd0, P1 = 3'd1, FX = 3'd2, LD = 3'd3, ST = 3'd4, NO = 3'd7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic alloc_valid = 1'b0;
    logic [2:0] alloc_class = '0;
    logic alloc_ready = 1'b0;
    logic [TAG_W-1:0] alloc_tag = '0;
    logic wake_valid = 1'b0;
    logic [TAG_W-1:0] wake_tag = '0;
    logic [4:0] port_busy = 5'b11111;
    logic [4:0] grant_valid;
    logic [5*TAG_W-1:0] grant_tag;
    logic [3:0] pool_count;
    logic pool_full;

    int n_chk = 0;
    int n_bad = 0;

    always #(PERIOD/2) clk = ~clk;

    uop_port_arbiter #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u0 (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_class(alloc_class),
        .alloc_ready(alloc_ready), .alloc_tag(alloc_tag),
        .wake_valid(wake_valid), .wake_tag(wake_tag),
        .port_busy(port_busy),
        .grant_valid(grant_valid), .grant_tag(grant_tag),
        .pool_count(pool_count), .pool_full(pool_full)
    );

    typedef struct packed {
        logic [3:0]       req;    // requirement number for the message
        logic [3:0][2:0]  cls;    // {e3,e2,e1,e0}, e0 oldest, tag = index+1
        logic [4:0]       busy;
        logic [4:0]       gv;
        logic [4:0][3:0]  tag;    // {p4,p3,p2,p1,p0}
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{4'd1, {ST,LD,P0,FX}, 5'b00000, 5'b11111, {4'd4,4'd4,4'd3,4'd1,4'd2}}, // R1 R3 mixed
        '{4'd4, {NO,FX,FX,FX}, 5'b00000, 5'b00011, {4'd0,4'd0,4'd0,4'd2,4'd1}}, // R4 two flex
        '{4'd3, {P0,FX,FX,P1}, 5'b00000, 5'b00011, {4'd0,4'd0,4'd0,4'd1,4'd4}}, // R3 fixed first
        '{4'd4, {NO,NO,P1,FX}, 5'b00000, 5'b00011, {4'd0,4'd0,4'd0,4'd2,4'd1}}, // R4 flex to p0
        '{4'd5, {LD,ST,LD,ST}, 5'b00000, 5'b11100, {4'd1,4'd1,4'd2,4'd0,4'd0}}, // R5 oldest
        '{4'd2, {NO,NO,LD,ST}, 5'b01000, 5'b00100, {4'd0,4'd0,4'd2,4'd0,4'd0}}, // R2 p3 busy
        '{4'd2, {NO,NO,LD,ST}, 5'b10000, 5'b00100, {4'd0,4'd0,4'd2,4'd0,4'd0}}, // R2 p4 busy
        '{4'd6, {P1,P0,FX,FX}, 5'b00001, 5'b00010, {4'd0,4'd0,4'd0,4'd4,4'd0}}, // R6 p0 busy
        '{4'd4, {NO,NO,FX,FX}, 5'b00010, 5'b00001, {4'd0,4'd0,4'd0,4'd0,4'd1}}, // R4 p1 busy
        '{4'd5, {P1,P1,P0,P0}, 5'b00000, 5'b00011, {4'd0,4'd0,4'd0,4'd3,4'd1}}, // R5 R1
        '{4'd9, {LD,3'd6,LD,3'd5}, 5'b00000, 5'b00100, {4'd0,4'd0,4'd2,4'd0,4'd0}}, // R9 bad class
        '{4'd6, {LD,LD,LD,LD}, 5'b11111, 5'b00000, {4'd0,4'd0,4'd0,4'd0,4'd0}}, // R6 all busy
        '{4'd2, {NO,NO,NO,ST}, 5'b00000, 5'b11000, {4'd1,4'd1,4'd0,4'd0,4'd0}}  // R2 store alone
    };

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    task automatic alloc(input logic [2:0] c, input logic [3:0] t, input logic r);
        alloc_valid = 1'b1; alloc_class = c; alloc_tag = t; alloc_ready = r;
        @(posedge clk); #1;
        alloc_valid = 1'b0;
    endtask

    function automatic logic [3:0] tag_of(input int p);
        return grant_tag[p*TAG_W +: TAG_W];
    endfunction

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        // R10: reset state
        do_reset();
        #2;
        check("R10", "reset grants", 32'(grant_valid), 32'h0);
        check("R10", "reset count", 32'(pool_count), 32'h0);
        check("R10", "reset full", 32'(pool_full), 32'h0);

        // table walk
        for (int v = 0; v < NV; v++) begin
            do_reset();
            port_busy = 5'b11111;
            for (int e = 0; e < 4; e++) alloc(VECS[v].cls[e], 4'(e + 1), 1'b1);
            port_busy = VECS[v].busy;
            #2;
            check($sformatf("R%0d v%0d", VECS[v].req, v), "grant_valid",
                  32'(grant_valid), 32'(VECS[v].gv));
            for (int k = 0; k < 5; k++)
                if (VECS[v].gv[k])
                    check($sformatf("R%0d v%0d", VECS[v].req, v), $sformatf("tag p%0d", k),
                          32'(tag_of(k)), 32'(VECS[v].tag[k]));
        end

        // R7: not-ready entry waits, wrong wake ignored, matching wake grants next cycle
        do_reset();
        port_busy = 5'b00000;
        alloc(LD, 4'd9, 1'b0);
        #2 check("R7", "not ready", 32'(grant_valid), 32'h0);
        wake_valid = 1'b1; wake_tag = 4'd8;
        @(posedge clk); #1 wake_valid = 1'b0;
        #2 check("R7", "wrong tag wake", 32'(grant_valid), 32'h0);
        check("R7", "count after wrong wake", 32'(pool_count), 32'd1);
        wake_valid = 1'b1; wake_tag = 4'd9;
        #2 check("R7", "same-cycle wake", 32'(grant_valid), 32'h0);
        @(posedge clk); #1 wake_valid = 1'b0;
        #2 check("R7", "woken grant", 32'(grant_valid), 32'h4);
        check("R7", "woken tag", 32'(tag_of(2)), 32'd9);
        @(posedge clk); #3;
        check("R8", "removed count", 32'(pool_count), 32'd0);
        check("R8", "no regrant", 32'(grant_valid), 32'h0);

        // R9/R10: fill to full, overflow write ignored, then drain in age order
        do_reset();
        port_busy = 5'b11111;
        for (int t = 1; t <= DEPTH; t++) alloc(LD, 4'(t), 1'b1);
        #2 check("R10", "full flag", 32'(pool_full), 32'd1);
        check("R10", "full count", 32'(pool_count), 32'(DEPTH));
        alloc(LD, 4'd15, 1'b1);
        #2 check("R9", "write while full", 32'(pool_count), 32'(DEPTH));
        port_busy = 5'b11011;
        for (int t = 1; t <= DEPTH; t++) begin
            #2;
            check("R5", "drain tag", 32'(tag_of(2)), 32'(t));
            check("R8", "drain count", 32'(pool_count), 32'(DEPTH - t + 1));
            if (t == 2) check("R10", "partial flag", 32'(pool_full), 32'd0);
            @(posedge clk); #1;
        end
        #2;
        check("R8", "drained count", 32'(pool_count), 32'd0);
        check("R9", "overflow never entered", 32'(grant_valid), 32'h0);

        finish_run();
    end
endmodule